// File: doc/BRIEF.md
# Programmable Serial Port with Receive and Transmit Queues

This block is an asynchronous serial transceiver. Characters written on the transmit side are placed in a queue and sent on `txd`. A character is one low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The receiver watches `rxd` with a 16x oversampling clock. It rebuilds each character and stores it in a receive queue together with three error bits: parity, framing and break. Each queue holds 16 entries. Either queue can be switched to a single-entry holding mode.

A fractional-free baud generator sets the line rate. It divides the master clock, or half of it, by a 16-bit divisor. A receive interrupt is raised when the receive queue reaches a programmable fill level. Line parameters are plain configuration inputs that are expected to stay stable while the line is active. The transmitter can also hold the line low to send a break.

Top module: `serial_port`

## Requirements
- R1: After reset, `txd` is high, `txFull` is low, `rxEmpty` is high, `rxCount` is 0, and `rxIrq` and `overrun` are low.
- R2: One bit lasts 16 oversampling ticks. A tick comes every `divisor` master-clock cycles, or every 2*`divisor` cycles when `clkHalf` is 1. A divisor of 0 acts as 1.
- R3: A transmitted frame has these bits in order. First a low start bit. Then 5+`dataLen` data bits, least significant bit first. Then, if `parityEn` is 1, a parity bit: the XOR of the data bits, inverted when `parityOdd` is 1. Then one high stop bit, or two when `twoStop` is 1. The idle line is high.
- R4: A received frame with the same format is stored with its data bits right-aligned in `rxData`, and the unused upper bits read 0. Each bit is sampled once, at tick 8 of the bit.
- R5: `rxErrParity` is set on a stored character when parity is enabled and the received parity bit does not match the parity computed from its data bits.
- R6: A character whose first stop bit samples low is still stored, with `rxErrFrame` set.
- R7: A low pulse on `rxd` that is high again at the middle of the start bit stores nothing.
- R8: While `breakCtl` is 1, `txd` is low. When `breakCtl` returns to 0 and no frame is in progress, `txd` is high.
- R9: A frame in which every sampled bit, stop bits included, is low is stored once with data 0 and with `rxErrBreak` and `rxErrFrame` set. The receiver then waits for `rxd` to go high before it looks for a new start bit.
- R10: The transmit queue holds 16 characters when `txFifoEn` is 1 and one character when it is 0. `txFull` is high at that limit.
- R11: The receive queue holds 16 entries when `rxFifoEn` is 1 and one entry when it is 0, and `rxCount` shows how many it holds. A character that completes while the queue is full is discarded and sets `overrun`. `overrun` stays set until `ovrClr` is pulsed.
- R12: When `rxFifoEn` is 1, `rxIrq` is high while `rxCount` is at least 2*`rxTrig`, where an `rxTrig` of 0 counts as 1. When `rxFifoEn` is 0, `rxIrq` is high while the holding register is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | 16 | Baud divisor |
| clkHalf | input | 1 | Divide the master clock by two before the divisor |
| dataLen | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Add and check a parity bit |
| parityOdd | input | 1 | Odd parity when set, even when clear |
| twoStop | input | 1 | Two stop bits instead of one |
| txFifoEn | input | 1 | Transmit queue depth 16 (1) or 1 (0) |
| rxFifoEn | input | 1 | Receive queue depth 16 (1) or 1 (0) |
| rxTrig | input | 3 | Receive interrupt level in eighths of the queue depth |
| breakCtl | input | 1 | Force the line low |
| txWrite | input | 1 | Write `txData` into the transmit queue |
| txData | input | 8 | Character to send |
| txFull | output | 1 | Transmit queue full |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |
| rxRead | input | 1 | Remove the head entry of the receive queue |
| rxData | output | 8 | Head character |
| rxErrParity | output | 1 | Head entry parity error |
| rxErrFrame | output | 1 | Head entry framing error |
| rxErrBreak | output | 1 | Head entry is a break |
| rxEmpty | output | 1 | Receive queue empty |
| rxCount | output | 5 | Receive queue occupancy |
| rxIrq | output | 1 | Receive level interrupt |
| overrun | output | 1 | Sticky overrun flag |
| ovrClr | input | 1 | Clear `overrun` |

## Verification
The transmitter is driven with three framings: 8 data bits with no parity, 5 bits with even parity and two stop bits, and 7 bits with odd parity. Comparing each captured frame against these separates bit ordering, masking and parity-sense faults. Start-bit widths are measured under two divisor and prescaler settings, which exposes a wrong tick period or a missing halving. On the receive side, clean frames are mixed with frames that have a flipped parity bit, frames with a low stop bit, a short glitch and a full-frame break, and each must produce its own distinct queue entry or none at all. A run of 17 frames without reads, with the queue first enabled and then disabled, checks the trigger level, the queue limit, the discard on overrun and the ordering of the surviving entries.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int FRAME_W = 12;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxClear;
    logic rxData;
    logic rxPar;
    logic rxStop1;
    logic rxStop2;
    logic rxPush;
  } strobe_t;

  typedef struct packed {
    logic       brk;
    logic       frame;
    logic       parity;
    logic [7:0] data;
  } rxEntry_t;
endpackage

// File: rtl/serial_fifo.sv
module serial_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop;

  assign full   = en ? (count == CW'(DEPTH)) : (count != '0);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import serial_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             clkHalf,
  input  logic [1:0]       dataLen,
  input  logic             parityEn,
  input  logic             twoStop,
  input  logic             txEmpty,
  input  logic             rxBit,
  input  logic             rxBreak,
  output strobe_t          st
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_DONE, RX_WAIT} rxState_t;

  logic             pre, en, tick;
  logic [DIV_W-1:0] cnt, divEff;
  logic [3:0]       nData, txLast, rxLast;
  logic             txBusy;
  logic [3:0]       txOs, txIdx, rxOs, rxIdx;
  rxState_t         rxState;
  logic             sampleNow;

  // baud tick
  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign en     = !clkHalf || pre;
  assign tick   = en && (cnt >= divEff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre <= 1'b0;
      cnt <= '0;
    end else begin
      pre <= ~pre;
      cnt <= tick ? '0 : (en ? cnt + 1'b1 : cnt);
    end
  end

  assign nData  = 4'd5 + {2'b0, dataLen};
  assign txLast = nData + {3'b0, parityEn} + 4'd1 + {3'b0, twoStop};
  assign rxLast = nData + {3'b0, parityEn} + {3'b0, twoStop};

  always_comb begin
    st = '0;
    st.txLoad  = !txBusy && tick && !txEmpty;
    st.txShift = txBusy && tick && (txOs == 4'd15);
    st.rxClear = (rxState == RX_IDLE) && tick && !rxBit;
    sampleNow  = (rxState == RX_BITS) && tick && (rxOs == 4'd15);
    if (sampleNow) begin
      if (rxIdx < nData)                              st.rxData  = 1'b1;
      else if (parityEn && rxIdx == nData)            st.rxPar   = 1'b1;
      else if (rxIdx == nData + {3'b0, parityEn})     st.rxStop1 = 1'b1;
      else                                            st.rxStop2 = 1'b1;
    end
    st.rxPush = (rxState == RX_DONE);
  end

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txOs   <= '0;
      txIdx  <= '0;
    end else if (st.txLoad) begin
      txBusy <= 1'b1;
      txOs   <= '0;
      txIdx  <= '0;
    end else if (txBusy && tick) begin
      txOs <= txOs + 1'b1;
      if (txOs == 4'd15) begin
        if (txIdx == txLast) txBusy <= 1'b0;
        else                 txIdx  <= txIdx + 1'b1;
      end
    end
  end

  // receive sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxOs    <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: if (st.rxClear) begin
          rxState <= RX_START;
          rxOs    <= '0;
        end
        RX_START: if (tick) begin
          if (rxOs == 4'd7) begin
            if (rxBit) rxState <= RX_IDLE;
            else begin
              rxState <= RX_BITS;
              rxOs    <= '0;
              rxIdx   <= '0;
            end
          end else rxOs <= rxOs + 1'b1;
        end
        RX_BITS: if (tick) begin
          rxOs <= rxOs + 1'b1;
          if (rxOs == 4'd15) begin
            if (rxIdx == rxLast) rxState <= RX_DONE;
            else                 rxIdx   <= rxIdx + 1'b1;
          end
        end
        RX_DONE: rxState <= rxBreak ? RX_WAIT : RX_IDLE;
        RX_WAIT: if (rxBit) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_datapath.sv
module serial_datapath
  import serial_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = $bits(rxEntry_t)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [1:0]    dataLen,
  input  logic          parityEn,
  input  logic          parityOdd,
  input  logic          txFifoEn,
  input  logic          rxFifoEn,
  input  logic [2:0]    rxTrig,
  input  logic          breakCtl,
  input  logic          txWrite,
  input  logic [7:0]    txData,
  output logic          txFull,
  output logic          txEmpty,
  output logic          txd,
  input  logic          rxd,
  output logic          rxBit,
  output logic          rxBreak,
  input  logic          rxRead,
  output logic [7:0]    rxData,
  output logic          rxErrParity,
  output logic          rxErrFrame,
  output logic          rxErrBreak,
  output logic          rxEmpty,
  output logic [CW-1:0] rxCount,
  output logic          rxIrq,
  output logic          overrun,
  input  logic          ovrClr
);
  logic [7:0]         txHead, mask, rxAligned, rxShift;
  logic [3:0]         nData;
  logic [FRAME_W-1:0] frame, txShreg;
  logic               txPar, rxMeta, rxParBit, rxFe, rxAny, rxFull;
  rxEntry_t           newEntry, head;
  logic [EW-1:0]      headRaw;
  logic [2:0]         lvl;
  logic [CW-1:0]      thr;

  assign nData = 4'd5 + {2'b0, dataLen};
  assign mask  = 8'hFF >> (2'd3 - dataLen);

  serial_fifo #(.W(8), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .en(txFifoEn), .push(txWrite), .pop(st.txLoad),
    .din(txData), .dout(txHead), .count(), .full(txFull), .empty(txEmpty));

  always_comb begin
    txPar = ^(txHead & mask) ^ parityOdd;
    frame = '1;
    for (int j = 0; j < FRAME_W; j++) begin
      if (j == 0)                                   frame[j] = 1'b0;
      else if (j <= int'(nData))                    frame[j] = txHead[3'(j - 1)];
      else if (parityEn && j == int'(nData) + 1)    frame[j] = txPar;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           txShreg <= '1;
    else if (st.txLoad)  txShreg <= frame;
    else if (st.txShift) txShreg <= {1'b1, txShreg[FRAME_W-1:1]};
  end
  assign txd = !breakCtl && txShreg[0];

  // receive capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxBit  <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxBit  <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.rxClear) begin
      rxShift  <= '0;
      rxParBit <= 1'b0;
      rxFe     <= 1'b0;
      rxAny    <= 1'b0;
    end else begin
      if (st.rxData)  rxShift  <= {rxBit, rxShift[7:1]};
      if (st.rxPar)   rxParBit <= rxBit;
      if (st.rxStop1) rxFe     <= !rxBit;
      if (st.rxData || st.rxPar || st.rxStop1 || st.rxStop2) rxAny <= rxAny | rxBit;
    end
  end

  assign rxAligned       = rxShift >> (2'd3 - dataLen);
  assign rxBreak         = !rxAny;
  assign newEntry.data   = rxAligned;
  assign newEntry.parity = parityEn && (rxParBit != (^rxAligned ^ parityOdd));
  assign newEntry.frame  = rxFe;
  assign newEntry.brk    = !rxAny;

  serial_fifo #(.W(EW), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .en(rxFifoEn), .push(st.rxPush), .pop(rxRead),
    .din(newEntry), .dout(headRaw), .count(rxCount), .full(rxFull), .empty(rxEmpty));

  assign head        = headRaw;
  assign rxData      = head.data;
  assign rxErrParity = head.parity;
  assign rxErrFrame  = head.frame;
  assign rxErrBreak  = head.brk;

  always_ff @(posedge clk) begin
    if (!rstN || ovrClr)          overrun <= 1'b0;
    else if (st.rxPush && rxFull) overrun <= 1'b1;
  end

  assign lvl   = (rxTrig == 3'd0) ? 3'd1 : rxTrig;
  assign thr   = CW'((int'(lvl) * DEPTH) / 8);
  assign rxIrq = rxFifoEn ? (rxCount >= thr) : rxFull;
endmodule

// File: rtl/serial_port.sv
module serial_port
  import serial_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             clkHalf,
  input  logic [1:0]       dataLen,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic             twoStop,
  input  logic             txFifoEn,
  input  logic             rxFifoEn,
  input  logic [2:0]       rxTrig,
  input  logic             breakCtl,
  input  logic             txWrite,
  input  logic [7:0]       txData,
  output logic             txFull,
  output logic             txd,
  input  logic             rxd,
  input  logic             rxRead,
  output logic [7:0]       rxData,
  output logic             rxErrParity,
  output logic             rxErrFrame,
  output logic             rxErrBreak,
  output logic             rxEmpty,
  output logic [CW-1:0]    rxCount,
  output logic             rxIrq,
  output logic             overrun,
  input  logic             ovrClr
);
  strobe_t st;
  logic    txEmpty, rxBit, rxBreak;

  serial_ctrl #(.DIV_W(DIV_W)) ctrl (
    .clk(clk), .rstN(rstN), .divisor(divisor), .clkHalf(clkHalf),
    .dataLen(dataLen), .parityEn(parityEn), .twoStop(twoStop),
    .txEmpty(txEmpty), .rxBit(rxBit), .rxBreak(rxBreak), .st(st));

  serial_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .st(st), .dataLen(dataLen), .parityEn(parityEn),
    .parityOdd(parityOdd), .txFifoEn(txFifoEn), .rxFifoEn(rxFifoEn),
    .rxTrig(rxTrig), .breakCtl(breakCtl), .txWrite(txWrite), .txData(txData),
    .txFull(txFull), .txEmpty(txEmpty), .txd(txd), .rxd(rxd), .rxBit(rxBit),
    .rxBreak(rxBreak), .rxRead(rxRead), .rxData(rxData),
    .rxErrParity(rxErrParity), .rxErrFrame(rxErrFrame), .rxErrBreak(rxErrBreak),
    .rxEmpty(rxEmpty), .rxCount(rxCount), .rxIrq(rxIrq), .overrun(overrun),
    .ovrClr(ovrClr));
endmodule

// File: rtl/serial_port_checker.sv
module serial_port_checker #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          breakCtl,
  input logic          txd,
  input logic          rxRead,
  input logic          rxEmpty,
  input logic [CW-1:0] rxCount,
  input logic          rxIrq,
  input logic          rxFifoEn,
  input logic          overrun
);
  assert_break_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    breakCtl |-> !txd);

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxCount) <= DEPTH);

  assert_overrun_full_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> int'($past(rxCount)) == ($past(rxFifoEn) ? DEPTH : 1));

  assert_read_drains_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !rxEmpty) |=> rxCount <= $past(rxCount));

  assert_irq_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> !rxEmpty);
endmodule

bind serial_port serial_port_checker #(.DEPTH(DEPTH)) portChecker (
  .clk(clk), .rstN(rstN), .breakCtl(breakCtl), .txd(txd), .rxRead(rxRead),
  .rxEmpty(rxEmpty), .rxCount(rxCount), .rxIrq(rxIrq), .rxFifoEn(rxFifoEn),
  .overrun(overrun));

// File: tb/serial_port_test.sv
module serial_port_test;
  localparam int BIT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        clkHalf = 1'b0;
  logic [1:0]  dataLen = 2'd3;
  logic        parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic        txFifoEn = 1'b1, rxFifoEn = 1'b1;
  logic [2:0]  rxTrig = 3'd2;
  logic        breakCtl = 1'b0, txWrite = 1'b0, rxd = 1'b1, rxRead = 1'b0, ovrClr = 1'b0;
  logic [7:0]  txData = '0;
  logic        txFull, txd, rxErrParity, rxErrFrame, rxErrBreak, rxEmpty, rxIrq, overrun;
  logic [7:0]  rxData;
  logic [4:0]  rxCount;

  int          nChecks = 0, nErrors = 0;
  logic [10:0] expQ[$];
  bit          mOvr = 0, cmpOn = 0;

  serial_port uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expIrq();
    int lvl = (rxTrig == 0) ? 1 : int'(rxTrig);
    if (rxFifoEn) return expQ.size() >= 2 * lvl;
    return expQ.size() != 0;
  endfunction

  // reference model compared on every clock while the line is quiet
  always @(negedge clk) begin
    if (cmpOn) begin
      chk(int'(rxCount) == expQ.size(), "R11 rxCount", int'(rxCount), expQ.size());
      chk(overrun == mOvr, "R11 overrun", int'(overrun), int'(mOvr));
      chk(rxIrq == expIrq(), "R12 rxIrq", int'(rxIrq), int'(expIrq()));
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expQ.delete();
    mOvr = 0;
    @(negedge clk);
  endtask

  task automatic modelPush(input logic [10:0] e);
    if (expQ.size() < (rxFifoEn ? 16 : 1)) expQ.push_back(e);
    else mOvr = 1;
  endtask

  task automatic drv(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic quietWindow();
    cmpOn = 1;
    repeat (BIT) @(negedge clk);
    cmpOn = 0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit stopLow, input bit flipPar);
    int n = 5 + int'(dataLen);
    logic [7:0] m = d & (8'hFF >> (3 - n + 5));
    drv(1'b0);
    for (int i = 0; i < n; i++) drv(m[i]);
    if (parityEn) drv(^m ^ parityOdd ^ flipPar);
    drv(!stopLow);
    if (twoStop) drv(1'b1);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
    modelPush({1'b0, stopLow, flipPar & parityEn, m});
    quietWindow();
  endtask

  task automatic readCheck(input string req);
    logic [10:0] e;
    chk(!rxEmpty, {req, " not empty"}, int'(rxEmpty), 0);
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    chk(rxData == e[7:0], {req, " data"}, int'(rxData), int'(e[7:0]));
    chk(rxErrParity == e[8], {req, " parity flag"}, int'(rxErrParity), int'(e[8]));
    chk(rxErrFrame == e[9], {req, " frame flag"}, int'(rxErrFrame), int'(e[9]));
    chk(rxErrBreak == e[10], {req, " break flag"}, int'(rxErrBreak), int'(e[10]));
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic writeTx(input logic [7:0] d);
    txData = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitFall();
    for (int i = 0; i < 20000 && txd; i++) @(negedge clk);
  endtask

  task automatic txFrameCheck(input logic [7:0] d, input string req);
    int n = 5 + int'(dataLen);
    int len = 0;
    logic [11:0] expB = '1, got = '1;
    logic [7:0] m = d & (8'hFF >> (8 - n));
    expB[len++] = 1'b0;
    for (int i = 0; i < n; i++) expB[len++] = m[i];
    if (parityEn) expB[len++] = ^m ^ parityOdd;
    expB[len++] = 1'b1;
    if (twoStop) expB[len++] = 1'b1;
    writeTx(d);
    waitFall();
    repeat (BIT / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < len; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = txd;
    end
    chk(got == expB, req, int'(got), int'(expB));
    repeat (BIT) @(negedge clk);
  endtask

  task automatic startWidth(input int expW, input string req);
    int w = 0;
    writeTx(8'h01);
    waitFall();
    while (!txd && w < 5000) begin
      w++;
      @(negedge clk);
    end
    chk(w == expW, req, w, expW);
    repeat (12 * expW) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    // R1 reset state
    divisor = 16'd1000;
    doReset();
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(txFull == 1'b0, "R1 txFull", int'(txFull), 0);
    chk(rxEmpty == 1'b1, "R1 rxEmpty", int'(rxEmpty), 1);
    chk(rxCount == 0, "R1 rxCount", int'(rxCount), 0);
    chk(rxIrq == 1'b0 && overrun == 1'b0, "R1 irq/overrun", int'({rxIrq, overrun}), 0);

    // R10 transmit queue depth (slow divisor keeps the queue from draining)
    for (int i = 0; i < 15; i++) writeTx(8'(i));
    chk(txFull == 1'b0, "R10 not full at 15", int'(txFull), 0);
    writeTx(8'h0F);
    chk(txFull == 1'b1, "R10 full at 16", int'(txFull), 1);
    txFifoEn = 1'b0;
    doReset();
    chk(txFull == 1'b0, "R10 holding empty", int'(txFull), 0);
    writeTx(8'h33);
    chk(txFull == 1'b1, "R10 holding full at 1", int'(txFull), 1);
    txFifoEn = 1'b1;
    divisor = 16'd1;
    doReset();

    // R3 frame formats
    txFrameCheck(8'hA5, "R3 8N1 frame");
    dataLen = 2'd0; parityEn = 1'b1; parityOdd = 1'b0; twoStop = 1'b1;
    txFrameCheck(8'h13, "R3 5E2 frame");
    dataLen = 2'd2; parityOdd = 1'b1; twoStop = 1'b0;
    txFrameCheck(8'h5A, "R3 7O1 frame");
    dataLen = 2'd3; parityEn = 1'b0; parityOdd = 1'b0;

    // R2 bit timing
    divisor = 16'd3;
    startWidth(48, "R2 start width div3");
    divisor = 16'd2; clkHalf = 1'b1;
    startWidth(64, "R2 start width div2 halved");
    divisor = 16'd1; clkHalf = 1'b0;
    doReset();

    // R8 transmit break
    breakCtl = 1'b1;
    repeat (3) @(negedge clk);
    chk(txd == 1'b0, "R8 break low", int'(txd), 0);
    breakCtl = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R8 break released", int'(txd), 1);

    // R4 receive, R5 parity, R6 framing
    sendFrame(8'h3C, 1'b0, 1'b0);
    readCheck("R4 8N1 receive");
    dataLen = 2'd1; parityEn = 1'b1; twoStop = 1'b1;
    sendFrame(8'h2B, 1'b0, 1'b0);
    readCheck("R4 6E2 receive");
    sendFrame(8'h2B, 1'b0, 1'b1);
    readCheck("R5 parity error");
    dataLen = 2'd3; parityEn = 1'b0; twoStop = 1'b0;
    sendFrame(8'h55, 1'b1, 1'b0);
    readCheck("R6 framing error");

    // R7 false start
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    quietWindow();
    chk(rxEmpty == 1'b1, "R7 glitch stores nothing", int'(rxEmpty), 1);

    // R9 receive break
    rxd = 1'b0;
    repeat (12 * BIT) @(negedge clk);
    chk(rxCount == 1, "R9 single entry while low", int'(rxCount), 1);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
    modelPush({1'b1, 1'b1, 1'b0, 8'h00});
    quietWindow();
    readCheck("R9 break entry");

    // R12 trigger level, R11 depth and overrun
    rxTrig = 3'd2;
    for (int i = 0; i < 3; i++) sendFrame(8'(8'h40 + i), 1'b0, 1'b0);
    chk(rxIrq == 1'b0, "R12 below level 4", int'(rxIrq), 0);
    sendFrame(8'h43, 1'b0, 1'b0);
    chk(rxIrq == 1'b1, "R12 at level 4", int'(rxIrq), 1);
    for (int i = 4; i < 17; i++) sendFrame(8'(8'h40 + i), 1'b0, 1'b0);
    chk(rxCount == 16, "R11 queue full at 16", int'(rxCount), 16);
    chk(overrun == 1'b1, "R11 overrun set", int'(overrun), 1);
    for (int i = 0; i < 16; i++) readCheck("R11 ordered drain");
    chk(rxEmpty == 1'b1, "R11 seventeenth discarded", int'(rxEmpty), 1);
    ovrClr = 1'b1;
    @(negedge clk);
    ovrClr = 1'b0;
    mOvr = 0;
    @(negedge clk);
    chk(overrun == 1'b0, "R11 overrun cleared", int'(overrun), 0);

    // R11/R12 holding-register mode
    rxFifoEn = 1'b0;
    doReset();
    sendFrame(8'h61, 1'b0, 1'b0);
    chk(rxIrq == 1'b1, "R12 holding full irq", int'(rxIrq), 1);
    sendFrame(8'h62, 1'b0, 1'b0);
    chk(overrun == 1'b1, "R11 holding overrun", int'(overrun), 1);
    readCheck("R11 holding keeps first");
    chk(rxEmpty == 1'b1, "R11 holding drained", int'(rxEmpty), 1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule